// File: doc/BRIEF.md
# Depth Tile Status Fast-Clear Controller

This block keeps a 2-bit status entry for every 4x4 tile of a depth buffer. Each tile holds 16 depth samples. The block answers lookups from a depth-test pipeline. For each lookup it reports whether the tile must be read in its packed (compressed) form, read in its full raw form, or not read at all because it is in the cleared state. A cleared tile is filled from a stored clear value. Tiles are always handled whole: touching even one sample means the whole tile is fetched or unpacked. When the pipeline writes a tile back, the block records the new state the writer reports.

A clear command only rewrites the status table. It never writes the depth memory. The table is swept at a fixed number of entries per cycle, and `busy` stays high until the sweep ends. A clear can only be fast when compression is enabled. With compression off, the command is passed on as a one-cycle request for a conventional clear, and the table is left alone. The compression codec and the depth memory itself sit outside this block.

Top module: `depth_tile_status_ctrl`

## Requirements
- R1: After reset every tile is in the raw state, `busy` is low, `lkValid` is low and `slowClrReq` is low.
- R2: A lookup accepted at a clock edge (`lkReq` high, `busy` low) raises `lkValid` for one cycle after that edge, with `lkState` coded as 00 raw, 01 packed, 10 cleared; code 11 is never reported.
- R3: `lkWords` gives the fetch size in depth words: TILE_SAMPLES (16) for a raw tile, 16/COMP_DIV for a packed tile, and 0 for a cleared tile.
- R4: For a cleared tile, `lkFill` carries the stored clear value in all 16 lanes, lane i at bits [i*DEPTH_W +: DEPTH_W]; for any other state `lkFill` is all zeros.
- R5: An accepted write-back sets the tile to packed when `wbCompressed` is 1 and to raw when it is 0. A lookup of the same tile at the same edge reports the state held before the write.
- R6: A clear command with `compEn` high latches `clrValue` and raises `busy` from the next cycle for exactly NUM_TILES/CLEAR_PER_CYCLE cycles. After that, every tile looks up as cleared.
- R7: Lookups and write-backs presented while `busy` is high are ignored: no `lkValid` is produced and no tile state changes.
- R8: A clear command with `compEn` low pulses `slowClrReq` for one cycle after the edge, leaves `busy` low, and changes no tile state.
- R9: A clear command presented while `busy` is high is ignored: the latched clear value is kept and the sweep is not extended.
- R10: A write-back to a cleared tile replaces the cleared state with the reported packed or raw state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| compEn | input | 1 | Tile compression enabled; fast clear allowed |
| clrReq | input | 1 | Clear command |
| clrValue | input | DEPTH_W | Depth value that cleared tiles read as |
| lkReq | input | 1 | Lookup request |
| lkTile | input | $clog2(NUM_TILES) | Tile index to look up |
| wbReq | input | 1 | Write-back request |
| wbTile | input | $clog2(NUM_TILES) | Tile index written back |
| wbCompressed | input | 1 | 1: tile written packed, 0: written raw |
| busy | output | 1 | Table sweep in progress; requests are dropped |
| slowClrReq | output | 1 | One-cycle request for a conventional clear |
| lkValid | output | 1 | Lookup result valid |
| lkState | output | 2 | Tile state code of the lookup |
| lkWords | output | $clog2(TILE_SAMPLES+1) | Depth words to fetch |
| lkFill | output | 16*DEPTH_W | Clear value replicated over the tile |

## Verification
The bench builds the block with 16 tiles, 4 entries cleared per cycle, 16-bit depth and a packing ratio of 4. That makes the sweep 4 cycles long. Requests and a second clear command can therefore be injected in the middle of a sweep, and a tile in an already-swept group can be targeted while the sweep is still running. The ratio of 4 puts the packed fetch size at a value different from the raw size and from the default ratio. The narrow depth keeps the 16-lane fill vector small enough to compare whole.

// File: rtl/dtsc_pkg.sv
package dtsc_pkg;

  typedef enum logic [1:0] {
    TS_RAW     = 2'b00,
    TS_PACKED  = 2'b01,
    TS_CLEARED = 2'b10,
    TS_RSVD    = 2'b11
  } tileState_e;

  typedef struct packed {
    logic latchClr;
    logic walkEn;
    logic lkFire;
    logic wbFire;
  } ctrlStrobe_t;

endpackage

// File: rtl/dtsc_ctrl.sv
module dtsc_ctrl
  import dtsc_pkg::*;
#(
  parameter int GROUPS = 16,
  parameter int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          compEn,
  input  logic          clrReq,
  input  logic          lkReq,
  input  logic          wbReq,
  output ctrlStrobe_t   strb,
  output logic [GW-1:0] grpIdx,
  output logic          busy,
  output logic          slowClr
);

  logic walking;
  logic lastGrp;

  assign lastGrp = (int'(grpIdx) == GROUPS - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      walking <= 1'b0;
      grpIdx  <= '0;
      slowClr <= 1'b0;
    end else begin
      slowClr <= clrReq && !walking && !compEn;
      if (!walking) begin
        grpIdx <= '0;
        if (clrReq && compEn) walking <= 1'b1;
      end else begin
        if (lastGrp) begin
          walking <= 1'b0;
          grpIdx  <= '0;
        end else begin
          grpIdx <= grpIdx + GW'(1);
        end
      end
    end
  end

  assign busy          = walking;
  assign strb.latchClr = !walking && clrReq && compEn;
  assign strb.walkEn   = walking;
  assign strb.lkFire   = !walking && lkReq;
  assign strb.wbFire   = !walking && wbReq;

  // R6: a sweep starts only from an accepted fast-clear command
  assert_sweep_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(clrReq && compEn));

  // R6: the group counter stays inside the table during a sweep
  assert_group_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (int'(grpIdx) < GROUPS));

  // R8: the fallback request never coincides with a sweep
  assert_slow_no_sweep_R8: assert property (@(posedge clk) disable iff (!rstN)
    slowClr |-> (!busy && $past(!compEn)));

endmodule

// File: rtl/dtsc_table.sv
module dtsc_table
  import dtsc_pkg::*;
#(
  parameter int NUM_TILES       = 64,
  parameter int CLEAR_PER_CYCLE = 4,
  parameter int DEPTH_W         = 24,
  parameter int COMP_DIV        = 2,
  parameter int TILE_SAMPLES    = 16,
  parameter int IW              = $clog2(NUM_TILES),
  parameter int GW              = 1,
  parameter int WW              = $clog2(TILE_SAMPLES + 1)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrobe_t                     strb,
  input  logic [GW-1:0]                   grpIdx,
  input  logic [DEPTH_W-1:0]              clrValue,
  input  logic [IW-1:0]                   lkTile,
  input  logic [IW-1:0]                   wbTile,
  input  logic                            wbCompressed,
  output logic                            lkValid,
  output logic [1:0]                      lkState,
  output logic [WW-1:0]                   lkWords,
  output logic [TILE_SAMPLES*DEPTH_W-1:0] lkFill
);

  localparam int PACKED_WORDS = TILE_SAMPLES / COMP_DIV;

  tileState_e         tbl [NUM_TILES];
  tileState_e         lkStateQ;
  tileState_e         curState;
  logic [DEPTH_W-1:0] clrVal;
  logic [WW-1:0]      wordsNext;

  assign curState = tbl[lkTile];

  always_comb begin
    unique case (curState)
      TS_RAW:    wordsNext = WW'(TILE_SAMPLES);
      TS_PACKED: wordsNext = WW'(PACKED_WORDS);
      default:   wordsNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_TILES; i++) tbl[i] <= TS_RAW;
      clrVal   <= '0;
      lkValid  <= 1'b0;
      lkStateQ <= TS_RAW;
      lkWords  <= '0;
      lkFill   <= '0;
    end else begin
      if (strb.latchClr) clrVal <= clrValue;
      if (strb.wbFire) tbl[wbTile] <= wbCompressed ? TS_PACKED : TS_RAW;
      if (strb.walkEn) begin
        for (int j = 0; j < CLEAR_PER_CYCLE; j++)
          tbl[IW'(int'(grpIdx) * CLEAR_PER_CYCLE + j)] <= TS_CLEARED;
      end
      lkValid <= strb.lkFire;
      if (strb.lkFire) begin
        lkStateQ <= curState;
        lkWords  <= wordsNext;
        lkFill   <= (curState == TS_CLEARED) ? {TILE_SAMPLES{clrVal}} : '0;
      end
    end
  end

  assign lkState = lkStateQ;

  // R2: the reserved code never leaves the block
  assert_no_reserved_R2: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |-> (lkState != 2'b11));

  // R7: a result only follows a lookup accepted outside a sweep
  assert_result_needs_fire_R7: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |-> $past(strb.lkFire && !strb.walkEn));

  // R4: non-cleared tiles carry no fill data
  assert_fill_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkState != 2'b10) |-> (lkFill == '0));

endmodule

// File: rtl/depth_tile_status_ctrl.sv
module depth_tile_status_ctrl
  import dtsc_pkg::*;
#(
  parameter int NUM_TILES       = 64,
  parameter int CLEAR_PER_CYCLE = 4,
  parameter int DEPTH_W         = 24,
  parameter int COMP_DIV        = 2,
  parameter int TILE_SAMPLES    = 16,
  parameter int IW              = $clog2(NUM_TILES),
  parameter int WW              = $clog2(TILE_SAMPLES + 1)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            compEn,
  input  logic                            clrReq,
  input  logic [DEPTH_W-1:0]              clrValue,
  input  logic                            lkReq,
  input  logic [IW-1:0]                   lkTile,
  input  logic                            wbReq,
  input  logic [IW-1:0]                   wbTile,
  input  logic                            wbCompressed,
  output logic                            busy,
  output logic                            slowClrReq,
  output logic                            lkValid,
  output logic [1:0]                      lkState,
  output logic [WW-1:0]                   lkWords,
  output logic [TILE_SAMPLES*DEPTH_W-1:0] lkFill
);

  localparam int GROUPS = NUM_TILES / CLEAR_PER_CYCLE;
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  ctrlStrobe_t   strb;
  logic [GW-1:0] grpIdx;

  dtsc_ctrl #(.GROUPS(GROUPS), .GW(GW)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .compEn  (compEn),
    .clrReq  (clrReq),
    .lkReq   (lkReq),
    .wbReq   (wbReq),
    .strb    (strb),
    .grpIdx  (grpIdx),
    .busy    (busy),
    .slowClr (slowClrReq)
  );

  dtsc_table #(
    .NUM_TILES       (NUM_TILES),
    .CLEAR_PER_CYCLE (CLEAR_PER_CYCLE),
    .DEPTH_W         (DEPTH_W),
    .COMP_DIV        (COMP_DIV),
    .TILE_SAMPLES    (TILE_SAMPLES),
    .IW              (IW),
    .GW              (GW),
    .WW              (WW)
  ) table_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .grpIdx       (grpIdx),
    .clrValue     (clrValue),
    .lkTile       (lkTile),
    .wbTile       (wbTile),
    .wbCompressed (wbCompressed),
    .lkValid      (lkValid),
    .lkState      (lkState),
    .lkWords      (lkWords),
    .lkFill       (lkFill)
  );

endmodule

// File: tb/depth_tile_status_ctrl_tb_top.sv
`timescale 1ns/1ps
module depth_tile_status_ctrl_tb_top;

  localparam int NT = 16;
  localparam int CPC = 4;
  localparam int DW = 16;
  localparam int CD = 4;
  localparam int NS = 16;
  localparam int IW = $clog2(NT);
  localparam int WW = $clog2(NS + 1);
  localparam int FW = NS * DW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic compEn = 1'b1;
  logic clrReq = 1'b0;
  logic [DW-1:0] clrValue = '0;
  logic lkReq = 1'b0;
  logic [IW-1:0] lkTile = '0;
  logic wbReq = 1'b0;
  logic [IW-1:0] wbTile = '0;
  logic wbCompressed = 1'b0;
  logic busy, slowClrReq, lkValid;
  logic [1:0] lkState;
  logic [WW-1:0] lkWords;
  logic [FW-1:0] lkFill;

  always #2.5 clk = ~clk;

  depth_tile_status_ctrl #(
    .NUM_TILES(NT), .CLEAR_PER_CYCLE(CPC), .DEPTH_W(DW), .COMP_DIV(CD)
  ) dut_i (
    .clk(clk), .rstN(rstN), .compEn(compEn), .clrReq(clrReq), .clrValue(clrValue),
    .lkReq(lkReq), .lkTile(lkTile), .wbReq(wbReq), .wbTile(wbTile),
    .wbCompressed(wbCompressed), .busy(busy), .slowClrReq(slowClrReq),
    .lkValid(lkValid), .lkState(lkState), .lkWords(lkWords), .lkFill(lkFill)
  );

  typedef struct {
    logic [1:0]    st;
    logic [WW-1:0] words;
    logic [FW-1:0] fill;
    string         tag;
  } expItem_t;

  expItem_t expQ[$];
  logic [1:0] model [NT];
  logic [DW-1:0] clrModel = '0;
  int checkCnt = 0;
  int failCnt = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic expItem_t mkExp(input logic [1:0] st, input string tag);
    expItem_t e;
    e.st = st;
    e.words = (st == 2'b00) ? WW'(NS) : (st == 2'b01) ? WW'(NS / CD) : '0;
    e.fill = (st == 2'b10) ? {NS{clrModel}} : '0;
    e.tag = tag;
    return e;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && lkValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R7 unexpected lkValid", FW'(lkState), '0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        chk(lkState == e.st, {e.tag, " state"}, FW'(lkState), FW'(e.st));
        chk(lkWords == e.words, {e.tag, " words R3"}, FW'(lkWords), FW'(e.words));
        chk(lkFill == e.fill, {e.tag, " fill R4"}, lkFill, e.fill);
      end
    end
  end

  task automatic doLook(input int tile, input string tag);
    @(negedge clk);
    lkReq = 1'b1;
    lkTile = IW'(tile);
    expQ.push_back(mkExp(model[tile], tag));
    @(negedge clk);
    lkReq = 1'b0;
  endtask

  task automatic doWb(input int tile, input bit comp);
    @(negedge clk);
    wbReq = 1'b1;
    wbTile = IW'(tile);
    wbCompressed = comp;
    @(negedge clk);
    wbReq = 1'b0;
    model[tile] = comp ? 2'b01 : 2'b00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < NT; i++) model[i] = 2'b00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy after reset", FW'(busy), '0);
    chk(lkValid == 1'b0, "R1 lkValid after reset", FW'(lkValid), '0);
    chk(slowClrReq == 1'b0, "R1 slowClrReq after reset", FW'(slowClrReq), '0);
    doLook(3, "R1 R2 raw tile 3");
    doLook(15, "R1 R2 raw tile 15");

    // R5 write-back packed and raw
    doWb(5, 1'b1);
    doLook(5, "R5 packed tile 5");
    doWb(7, 1'b0);
    doLook(7, "R5 raw tile 7");

    // R5 same-edge write and lookup of tile 6: old state reported
    @(negedge clk);
    wbReq = 1'b1; wbTile = IW'(6); wbCompressed = 1'b1;
    lkReq = 1'b1; lkTile = IW'(6);
    expQ.push_back(mkExp(model[6], "R5 same-edge old state"));
    @(negedge clk);
    wbReq = 1'b0; lkReq = 1'b0;
    model[6] = 2'b01;
    doLook(6, "R5 tile 6 after write");

    // R8 clear with compression disabled
    @(negedge clk);
    compEn = 1'b0; clrReq = 1'b1; clrValue = 16'h5555;
    @(negedge clk);
    clrReq = 1'b0;
    chk(slowClrReq == 1'b1, "R8 slowClrReq pulse", FW'(slowClrReq), 1);
    chk(busy == 1'b0, "R8 busy stays low", FW'(busy), 0);
    @(negedge clk);
    chk(slowClrReq == 1'b0, "R8 slowClrReq one cycle", FW'(slowClrReq), 0);
    compEn = 1'b1;
    doLook(5, "R8 tile 5 unchanged");

    // R6 fast clear, with R7 and R9 stimulus mid-sweep
    @(negedge clk);
    clrReq = 1'b1; clrValue = 16'hBEEF;
    @(negedge clk);
    clrReq = 1'b0;
    clrModel = 16'hBEEF;
    n = 0;
    while (busy && n < 100) begin
      n++;
      if (n == 1) begin
        lkReq = 1'b1; lkTile = IW'(1);
        wbReq = 1'b1; wbTile = IW'(0); wbCompressed = 1'b1;
        clrReq = 1'b1; clrValue = 16'h1234;
      end else begin
        lkReq = 1'b0; wbReq = 1'b0; clrReq = 1'b0;
      end
      @(negedge clk);
    end
    lkReq = 1'b0; wbReq = 1'b0; clrReq = 1'b0;
    chk(n == NT / CPC, "R6 R9 busy length", FW'(n), FW'(NT / CPC));
    for (int i = 0; i < NT; i++) model[i] = 2'b10;
    doLook(0, "R6 R7 tile 0 cleared");
    doLook(5, "R6 tile 5 cleared");
    doLook(15, "R6 tile 15 cleared");
    doLook(10, "R9 clear value kept");

    // R10 write-back replaces cleared state
    doWb(2, 1'b0);
    doLook(2, "R10 tile 2 raw");
    doWb(9, 1'b1);
    doLook(9, "R10 tile 9 packed");
    doLook(3, "R10 tile 3 still cleared");

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R2 missing results", FW'(expQ.size()), 0);
    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule